// File: doc/BRIEF.md
# Clock Source Enable and Ready Controller

This block sits in a small clock controller and decides, cycle by cycle, which clock sources are actually running. There are four sources: a fast internal oscillator, a fast external source, a slow internal oscillator and a main PLL. Software supplies one enable bit per source, a PLL input choice, a clock-security enable and writes to a system-clock selector. Hardware then adjusts these requests. The source in use as system clock is kept running. Sources are stopped in low-power modes. The slow oscillator is held on while the watchdog counts. A detected failure of the external source shuts that source down.

Every source has a simple timing model that stands in for the analog part. Its ready flag rises a set number of cycles after the run signal asserts, and falls a set number of cycles (six by default) after the run signal drops. Software polls a ready flag before it moves the system clock to that source. The selector refuses any move to a source that is not ready. When the external source fails, a non-maskable failure flag is raised. If that source was feeding the system clock, the system clock falls back to the fast internal oscillator.

Top module: `clk_src_ctrl`

## Requirements
- R1: Reset state. While the synchronous active-low reset is held, and in the first cycle after it is released, sysclk_sel is 0 (internal fast oscillator), hsi_run is 1, the other three run outputs are 0, all four ready flags are 0 and fail_nmi is 0.
- R2: A ready flag rises exactly N clock edges after its run signal asserts and stays high. N is a parameter per source, with defaults of 16 for the internal fast oscillator, 32 for the external source, 16 for the slow oscillator and 64 for the PLL.
- R3: A ready flag falls exactly OFF_CYCLES (default 6) edges after its run signal drops. If run returns before that, the flag stays high and no new start-up delay is applied.
- R4: While stop_req or standby_req is high, hsi_run, hse_run and pll_run are all 0, whatever the software enables are.
- R5: While either low-power request is high, sysclk_sel is forced to 0. When the requests are released, hsi_run is 1 at once and sysclk_sel is 0.
- R6: hsi_run is 1 whenever sysclk_sel is 0 and no low-power request is high, even when hsi_en_sw is 0. When the source is not in use, hsi_run follows hsi_en_sw.
- R7: Clearing pll_en_sw has no effect on pll_run while sysclk_sel is 2 (PLL).
- R8: lsi_run is 1 whenever wdg_active is 1, whatever lsi_en_sw is.
- R9: A pulse on sel_wr loads sel_req into sysclk_sel on the next edge (codes 0 internal fast, 1 external, 2 PLL) only if the target's ready flag is 1. Code 3, or a write to a source that is not ready, leaves sysclk_sel unchanged.
- R10: If hse_fail_det is seen while css_en_sw and hse_run are both 1, hse_run is 0 and fail_nmi is 1 after the next edge. With css_en_sw at 0, hse_fail_det has no effect.
- R11: On such a failure, if sysclk_sel was 1, or was 2 with pll_src_ext_sw at 1, then sysclk_sel is 0 after the next edge.
- R12: fail_nmi stays 1 until a fail_clr pulse clears it; a new failure in the same cycle wins. After a failure, hse_run stays 0 until hse_en_sw has been low for at least one cycle.
- R13: pll_run is 1 only while the PLL input chosen by pll_src_ext_sw (0 internal fast, 1 external) is running and ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsi_en_sw | input | 1 | Software enable, internal fast oscillator |
| hse_en_sw | input | 1 | Software enable, external fast source |
| lsi_en_sw | input | 1 | Software enable, internal slow oscillator |
| pll_en_sw | input | 1 | Software enable, main PLL |
| pll_src_ext_sw | input | 1 | PLL input: 0 internal fast, 1 external |
| css_en_sw | input | 1 | Clock-security enable |
| sel_req | input | 2 | Requested system-clock code |
| sel_wr | input | 1 | Write strobe for sel_req |
| stop_req | input | 1 | Stop mode active |
| standby_req | input | 1 | Standby mode active |
| wdg_active | input | 1 | Watchdog running |
| hse_fail_det | input | 1 | External source failure detected |
| fail_clr | input | 1 | Write-one-to-clear for fail_nmi |
| hsi_run | output | 1 | Internal fast oscillator run |
| hse_run | output | 1 | External source run |
| lsi_run | output | 1 | Slow oscillator run |
| pll_run | output | 1 | PLL run |
| hsi_rdy | output | 1 | Internal fast oscillator ready |
| hse_rdy | output | 1 | External source ready |
| lsi_rdy | output | 1 | Slow oscillator ready |
| pll_rdy | output | 1 | PLL ready |
| sysclk_sel | output | 2 | Current system-clock source code |
| fail_nmi | output | 1 | Sticky non-maskable failure flag |

## Verification
The bench counts edges exactly on both sides of each ready transition. A timer that is off by one flips the flag one cycle early or late. A fall model that restarts on re-enable drops the flag. The bench tries to switch to a source that is not ready, and to the reserved code; a selector without the ready gate jumps to a dead clock. It clears the enable of the in-use source and the PLL enable while the PLL is in use; a design without the hold stops the running system clock. Failures are injected with security both off and on, and with the external source in use both directly and through the PLL. A design that gets these wrong either leaves the system on a dead source, loses the sticky flag, or restarts the external source before software has acknowledged the failure.

// File: rtl/clk_src_pkg.sv
// Shared types for the clock source controller: system-clock codes and
// source index constants used to address per-source vectors.
package clk_src_pkg;
    typedef enum logic [1:0] {
        SRC_HSI  = 2'd0,
        SRC_HSE  = 2'd1,
        SRC_PLL  = 2'd2,
        SRC_RSVD = 2'd3
    } src_sel_e;

    localparam int NUM_SRC = 4;
    localparam int IDX_HSI = 0;
    localparam int IDX_HSE = 1;
    localparam int IDX_LSI = 2;
    localparam int IDX_PLL = 3;
endpackage

// File: rtl/osc_ready_model.sv
// Timing model of one oscillator: the ready flag rises ON_CYCLES edges after
// run asserts and falls OFF_CYCLES edges after run drops. Assumes both counts
// are at least 1. A run glitch during the fall window keeps ready high.
module osc_ready_model #(
    parameter int ON_CYCLES  = 16,
    parameter int OFF_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic rdy
);
    localparam int MAX_CNT = (ON_CYCLES > OFF_CYCLES) ? ON_CYCLES : OFF_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_CYCLES - 1);
    localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Counts start-up or shut-down cycles and flips the ready flag at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            rdy <= 1'b0;
        end else if (run) begin
            if (!rdy) begin
                if (cnt == ON_LAST) begin
                    rdy <= 1'b1;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end else begin
            if (rdy) begin
                if (cnt == OFF_LAST) begin
                    rdy <= 1'b0;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end

    // R2: ready only rises after a cycle in which the source was running.
    a_r2_rise_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(run));
    // R3: ready only falls after a cycle in which the source was stopped.
    a_r3_fall_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> !$past(run));
endmodule

// File: rtl/src_fail_guard.sv
// Clock-security logic for the external source: detects a qualified failure,
// locks the source off until software drops its enable, and holds a sticky
// interrupt flag that is cleared by a write-one-to-clear pulse.
module src_fail_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic css_en,
    input  logic fail_det,
    input  logic hse_running,
    input  logic hse_en_sw,
    input  logic fail_clr,
    output logic fail_evt,
    output logic hse_lock,
    output logic fail_flag
);
    // A failure counts only with security enabled and the source running.
    always_comb fail_evt = css_en && fail_det && hse_running;

    // Lock holds the source off from the failure until the enable is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)          hse_lock <= 1'b0;
        else if (fail_evt)   hse_lock <= 1'b1;
        else if (!hse_en_sw) hse_lock <= 1'b0;
    end

    // Sticky interrupt flag; a new failure wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        fail_flag <= 1'b0;
        else if (fail_evt) fail_flag <= 1'b1;
        else if (fail_clr) fail_flag <= 1'b0;
    end

    // R12: the flag never drops without a clear request.
    a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fail_flag) |-> $past(fail_clr));
    // R10: a qualified failure always leaves the flag set.
    a_r10_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fail_evt |=> fail_flag);
endmodule

// File: rtl/sysclk_select.sv
// System-clock selector: holds the current source code. Reset, low power and
// a failure of the source in use force the internal fast oscillator; a
// software write is accepted only for a valid code whose source is ready.
module sysclk_select
    import clk_src_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lp_active,
    input  logic       fail_evt,
    input  logic       pll_src_ext,
    input  logic [1:0] sel_req,
    input  logic       sel_wr,
    input  logic       hsi_rdy,
    input  logic       hse_rdy,
    input  logic       pll_rdy,
    output src_sel_e   sel
);
    logic     target_ok;
    logic     hse_in_use;
    src_sel_e req_code;

    // Decodes the request and checks the target's ready flag.
    always_comb begin
        req_code = src_sel_e'(sel_req);
        case (req_code)
            SRC_HSI: target_ok = hsi_rdy;
            SRC_HSE: target_ok = hse_rdy;
            SRC_PLL: target_ok = pll_rdy;
            default: target_ok = 1'b0;
        endcase
    end

    // Flags that the external source feeds the system clock now.
    always_comb hse_in_use = (sel == SRC_HSE) || ((sel == SRC_PLL) && pll_src_ext);

    // Updates the selection with hardware overrides taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                         sel <= SRC_HSI;
        else if (lp_active)                 sel <= SRC_HSI;
        else if (fail_evt && hse_in_use)    sel <= SRC_HSI;
        else if (sel_wr && target_ok)       sel <= req_code;
    end

    // R9: a move onto the external source requires it to have been ready.
    a_r9_hse_ready_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(sel) && sel == SRC_HSE) |-> $past(hse_rdy));
    // R9: a move onto the PLL requires it to have been ready.
    a_r9_pll_ready_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(sel) && sel == SRC_PLL) |-> $past(pll_rdy));
    // R9: the reserved code is never held.
    a_r9_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        sel != SRC_RSVD);
    // R5: low power leaves the internal fast oscillator selected.
    a_r5_lp_selects_hsi: assert property (@(posedge clk) disable iff (!rst_n)
        lp_active |=> sel == SRC_HSI);
endmodule

// File: rtl/clk_src_ctrl.sv
// Top of the clock source controller. Combines software enables with the
// hardware overrides (in-use hold, low-power stop, watchdog hold, failure
// lock, PLL input gating) into run signals and drives one timing model per
// source. Assumes the PLL input choice only changes while the PLL is off.
module clk_src_ctrl
    import clk_src_pkg::*;
#(
    parameter int HSI_ON_CYCLES = 16,
    parameter int HSE_ON_CYCLES = 32,
    parameter int LSI_ON_CYCLES = 16,
    parameter int PLL_ON_CYCLES = 64,
    parameter int OFF_CYCLES    = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hsi_en_sw,
    input  logic       hse_en_sw,
    input  logic       lsi_en_sw,
    input  logic       pll_en_sw,
    input  logic       pll_src_ext_sw,
    input  logic       css_en_sw,
    input  logic [1:0] sel_req,
    input  logic       sel_wr,
    input  logic       stop_req,
    input  logic       standby_req,
    input  logic       wdg_active,
    input  logic       hse_fail_det,
    input  logic       fail_clr,
    output logic       hsi_run,
    output logic       hse_run,
    output logic       lsi_run,
    output logic       pll_run,
    output logic       hsi_rdy,
    output logic       hse_rdy,
    output logic       lsi_rdy,
    output logic       pll_rdy,
    output logic [1:0] sysclk_sel,
    output logic       fail_nmi
);
    localparam int ON_TAB [NUM_SRC] = '{HSI_ON_CYCLES, HSE_ON_CYCLES,
                                        LSI_ON_CYCLES, PLL_ON_CYCLES};

    logic [NUM_SRC-1:0] run_vec;
    logic [NUM_SRC-1:0] rdy_vec;
    logic               lp_active;
    logic               fail_evt;
    logic               hse_lock;
    logic               pll_in_ok;
    src_sel_e           sel;

    // Either low-power request stops the fast sources.
    always_comb lp_active = stop_req || standby_req;

    // Run decision per source from enables and hardware overrides.
    always_comb begin
        run_vec[IDX_HSI] = !lp_active && (hsi_en_sw || sel == SRC_HSI);
        run_vec[IDX_HSE] = !lp_active && hse_en_sw && !hse_lock;
        run_vec[IDX_LSI] = lsi_en_sw || wdg_active;
        pll_in_ok        = pll_src_ext_sw ? (run_vec[IDX_HSE] && rdy_vec[IDX_HSE])
                                          : (run_vec[IDX_HSI] && rdy_vec[IDX_HSI]);
        run_vec[IDX_PLL] = !lp_active && pll_in_ok && (pll_en_sw || sel == SRC_PLL);
    end

    // One start-up and shut-down model per source.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_osc
        osc_ready_model #(
            .ON_CYCLES (ON_TAB[g]),
            .OFF_CYCLES(OFF_CYCLES)
        ) u_model (
            .clk  (clk),
            .rst_n(rst_n),
            .run  (run_vec[g]),
            .rdy  (rdy_vec[g])
        );
    end

    src_fail_guard u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .css_en     (css_en_sw),
        .fail_det   (hse_fail_det),
        .hse_running(run_vec[IDX_HSE]),
        .hse_en_sw  (hse_en_sw),
        .fail_clr   (fail_clr),
        .fail_evt   (fail_evt),
        .hse_lock   (hse_lock),
        .fail_flag  (fail_nmi)
    );

    sysclk_select u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .lp_active  (lp_active),
        .fail_evt   (fail_evt),
        .pll_src_ext(pll_src_ext_sw),
        .sel_req    (sel_req),
        .sel_wr     (sel_wr),
        .hsi_rdy    (rdy_vec[IDX_HSI]),
        .hse_rdy    (rdy_vec[IDX_HSE]),
        .pll_rdy    (rdy_vec[IDX_PLL]),
        .sel        (sel)
    );

    // Drives the named outputs from the per-source vectors.
    always_comb begin
        hsi_run    = run_vec[IDX_HSI];
        hse_run    = run_vec[IDX_HSE];
        lsi_run    = run_vec[IDX_LSI];
        pll_run    = run_vec[IDX_PLL];
        hsi_rdy    = rdy_vec[IDX_HSI];
        hse_rdy    = rdy_vec[IDX_HSE];
        lsi_rdy    = rdy_vec[IDX_LSI];
        pll_rdy    = rdy_vec[IDX_PLL];
        sysclk_sel = sel;
    end

    // R4: low power keeps the fast sources stopped.
    a_r4_lp_stops_fast: assert property (@(posedge clk) disable iff (!rst_n)
        lp_active |-> (!hsi_run && !hse_run && !pll_run));
    // R6: the in-use internal fast oscillator keeps running.
    a_r6_hsi_held: assert property (@(posedge clk) disable iff (!rst_n)
        (sysclk_sel == 2'd0 && !lp_active) |-> hsi_run);
    // R7: a PLL in use is not stopped by its enable bit.
    a_r7_pll_held: assert property (@(posedge clk) disable iff (!rst_n)
        (sysclk_sel == 2'd2 && $past(sysclk_sel) == 2'd2 && $past(pll_run)
         && !lp_active && $stable(pll_src_ext_sw) && !fail_evt) |-> pll_run);
    // R8: the watchdog keeps the slow oscillator alive.
    a_r8_wdg_holds_lsi: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_active |-> lsi_run);
    // R13: the PLL never runs from an input that is not ready.
    a_r13_pll_input_ready: assert property (@(posedge clk) disable iff (!rst_n)
        pll_run |-> (pll_src_ext_sw ? hse_rdy : hsi_rdy));
    // R10: after a failure is flagged, the external source is stopped.
    a_r10_hse_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_nmi) |-> !hse_run);
endmodule

// File: tb/clk_src_ctrl_test.sv
module clk_src_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsi_en_sw = 0, hse_en_sw = 0, lsi_en_sw = 0, pll_en_sw = 0;
    logic pll_src_ext_sw = 0, css_en_sw = 0;
    logic [1:0] sel_req = 2'd0;
    logic sel_wr = 0, stop_req = 0, standby_req = 0, wdg_active = 0;
    logic hse_fail_det = 0, fail_clr = 0;
    logic hsi_run, hse_run, lsi_run, pll_run;
    logic hsi_rdy, hse_rdy, lsi_rdy, pll_rdy;
    logic [1:0] sysclk_sel;
    logic fail_nmi;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    clk_src_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .hsi_en_sw(hsi_en_sw), .hse_en_sw(hse_en_sw), .lsi_en_sw(lsi_en_sw),
        .pll_en_sw(pll_en_sw), .pll_src_ext_sw(pll_src_ext_sw), .css_en_sw(css_en_sw),
        .sel_req(sel_req), .sel_wr(sel_wr), .stop_req(stop_req),
        .standby_req(standby_req), .wdg_active(wdg_active),
        .hse_fail_det(hse_fail_det), .fail_clr(fail_clr),
        .hsi_run(hsi_run), .hse_run(hse_run), .lsi_run(lsi_run), .pll_run(pll_run),
        .hsi_rdy(hsi_rdy), .hse_rdy(hse_rdy), .lsi_rdy(lsi_rdy), .pll_rdy(pll_rdy),
        .sysclk_sel(sysclk_sel), .fail_nmi(fail_nmi)
    );

    // Vector table for selector writes: {request code, expected selection}.
    // Starting point: internal fast and external ready, PLL not ready.
    localparam int NVEC = 7;
    localparam logic [3:0] SEL_VEC [NVEC] = '{
        {2'd1, 2'd1}, {2'd0, 2'd0}, {2'd2, 2'd0}, {2'd3, 2'd0},
        {2'd1, 2'd1}, {2'd3, 2'd1}, {2'd0, 2'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_sel(input logic [1:0] code);
        sel_req = code;
        sel_wr  = 1'b1;
        cyc(1);
        sel_wr  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc(3);
        // R1: reset state
        chk("R1 sel", sysclk_sel, 0);
        chk("R1 hsi_run", hsi_run, 1);
        chk("R1 other runs", {hse_run, lsi_run, pll_run}, 0);
        chk("R1 ready flags", {hsi_rdy, hse_rdy, lsi_rdy, pll_rdy}, 0);
        chk("R1 nmi", fail_nmi, 0);
        rst_n = 1'b1;
        #1 chk("R6 hsi held with enable low", hsi_run, 1);
        cyc(15);
        chk("R2 hsi not yet ready", hsi_rdy, 0);
        cyc(1);
        chk("R2 hsi ready at 16", hsi_rdy, 1);

        // R2 / R3 on the slow oscillator
        lsi_en_sw = 1;
        cyc(15);
        chk("R2 lsi not yet ready", lsi_rdy, 0);
        cyc(1);
        chk("R2 lsi ready at 16", lsi_rdy, 1);
        lsi_en_sw = 0;
        #1 chk("R3 lsi run off", lsi_run, 0);
        cyc(5);
        chk("R3 lsi still ready at 5", lsi_rdy, 1);
        cyc(1);
        chk("R3 lsi low at 6", lsi_rdy, 0);
        lsi_en_sw = 1;
        cyc(16);
        lsi_en_sw = 0;
        cyc(3);
        lsi_en_sw = 1;
        cyc(10);
        chk("R3 re-enable keeps ready", lsi_rdy, 1);
        lsi_en_sw = 0;
        cyc(8);

        // R8: watchdog hold
        wdg_active = 1;
        #1 chk("R8 lsi held by watchdog", lsi_run, 1);
        cyc(16);
        chk("R8 lsi ready under watchdog", lsi_rdy, 1);
        wdg_active = 0;
        #1 chk("R8 lsi released", lsi_run, 0);
        cyc(8);

        // R13: PLL from external input that is not running
        pll_src_ext_sw = 1;
        pll_en_sw = 1;
        #1 chk("R13 pll gated by input", pll_run, 0);
        pll_en_sw = 0;

        // R2: external source start-up
        hse_en_sw = 1;
        cyc(31);
        chk("R2 hse not yet ready", hse_rdy, 0);
        cyc(1);
        chk("R2 hse ready at 32", hse_rdy, 1);

        // R9: table of selector writes
        for (int i = 0; i < NVEC; i++) begin
            write_sel(SEL_VEC[i][3:2]);
            chk("R9 selector write", sysclk_sel, int'(SEL_VEC[i][1:0]));
        end

        // R13 / R2: PLL from ready external input
        pll_en_sw = 1;
        #1 chk("R13 pll runs with ready input", pll_run, 1);
        cyc(63);
        chk("R2 pll not yet ready", pll_rdy, 0);
        cyc(1);
        chk("R2 pll ready at 64", pll_rdy, 1);
        write_sel(2'd2);
        chk("R9 switch to pll", sysclk_sel, 2);
        #1 chk("R6 hsi off when unused", hsi_run, 0);
        pll_en_sw = 0;
        #1 chk("R7 pll held in use", pll_run, 1);
        cyc(10);
        chk("R7 pll still ready", pll_rdy, 1);

        // R10: failure ignored without clock security
        hse_fail_det = 1;
        cyc(1);
        hse_fail_det = 0;
        chk("R10 no nmi without security", fail_nmi, 0);
        chk("R10 hse kept without security", hse_run, 1);

        // R10 / R11: failure while PLL from external is in use
        css_en_sw = 1;
        hse_fail_det = 1;
        cyc(1);
        hse_fail_det = 0;
        chk("R10 hse stopped", hse_run, 0);
        chk("R10 nmi raised", fail_nmi, 1);
        chk("R11 fallback via pll", sysclk_sel, 0);
        cyc(3);
        chk("R12 nmi sticky", fail_nmi, 1);
        chk("R12 hse stays locked", hse_run, 0);
        fail_clr = 1;
        cyc(1);
        fail_clr = 0;
        chk("R12 nmi cleared", fail_nmi, 0);
        hse_en_sw = 0;
        cyc(8);
        hse_en_sw = 1;
        #1 chk("R12 hse re-armed", hse_run, 1);
        cyc(32);
        cyc(16);

        // R11: failure with external source used directly
        write_sel(2'd1);
        chk("R9 switch to hse", sysclk_sel, 1);
        hse_fail_det = 1;
        fail_clr = 1;
        cyc(1);
        hse_fail_det = 0;
        fail_clr = 0;
        chk("R11 fallback direct", sysclk_sel, 0);
        chk("R12 set wins over clear", fail_nmi, 1);
        fail_clr = 1;
        cyc(1);
        fail_clr = 0;
        hse_en_sw = 0;
        cyc(8);
        hse_en_sw = 1;
        cyc(40);

        // R4 / R5: stop mode with external source selected
        write_sel(2'd1);
        chk("R9 switch to hse again", sysclk_sel, 1);
        stop_req = 1;
        #1 chk("R4 stop forces off", {hsi_run, hse_run, pll_run}, 0);
        cyc(6);
        chk("R3 hsi ready drops in stop", hsi_rdy, 0);
        chk("R5 sel forced in stop", sysclk_sel, 0);
        stop_req = 0;
        #1 chk("R5 hsi on at wake", hsi_run, 1);
        chk("R5 sel at wake", sysclk_sel, 0);
        cyc(20);
        standby_req = 1;
        #1 chk("R4 standby forces off", {hsi_run, hse_run, pll_run}, 0);
        cyc(2);
        standby_req = 0;
        #1 chk("R5 hsi on after standby", hsi_run, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule